// File: doc/BRIEF.md
# Oversampled Serial Bus Receive Decoder

This block sits on the receive side of one channel of a time-slotted serial bus. The line is sampled eight times per bit time. A sample-enable input sets the data rate, so the same logic serves each of the three selectable rates. The decoder takes a majority vote over the most recent samples, which removes short glitches. It realigns its bit timing on every falling edge of the voted signal and takes one bit per bit time. Each byte on the line carries a two-bit start sequence (a high bit, then a low bit) followed by eight data bits, most significant bit first. The decoder removes the start sequences and passes each complete byte to a receive buffer with a one-clock write pulse.

Reception is bounded by slot-start and slot-end strobes. While the slot is open, the decoder records coding errors locally. It reaches a verdict on the slot only when the slot closes. The slot is good if at least one byte arrived, no coding error occurred and no frame was still in progress at the boundary. It is bad if any of these failed. An empty slot yields neither verdict. Activity on the line outside a slot is ignored.

Top module: `osr_rx_decoder`

## Requirements
- R1: After reset, `byte_we`, `frame_ok` and `frame_bad` are low.
- R2: The voted line value is the majority of the last five samples, so a single inverted sample in the middle of a bit does not change any decoded byte.
- R3: The bit timer restarts on every falling edge of the voted signal and takes a bit on the fifth sample after that edge. A high start bit lengthened or shortened by two samples therefore still decodes correctly.
- R4: Data bits are packed most significant bit first. Each completed byte appears on `byte_data` together with a `byte_we` pulse that lasts exactly one clock, and exactly one pulse is produced per byte sent.
- R5: While idle, the first low bit taken inside a slot starts a frame. After each byte, a high bit followed by a low bit starts the next byte. A high bit followed by another high bit ends the frame, and the decoder returns to idle.
- R6: A low bit in place of the high bit of a byte-start sequence is a coding error. No further bytes are written in that slot, and the slot ends with `frame_bad`.
- R7: If `slot_end` arrives while a frame is still in progress (inside a byte or inside a start sequence), the slot ends with `frame_bad`.
- R8: `frame_ok` and `frame_bad` are single-clock pulses, never both high, in the clock after `slot_end` of an open slot. `frame_ok` requires at least one byte and no error. A slot with no bytes and no error gives neither pulse.
- R9: `slot_start` clears the error state and the byte record of the previous slot.
- R10: Bits on the line outside a slot (after `slot_end`, before the next `slot_start`) produce no `byte_we`.
- R11: The decoder advances only on `samp_en`. The same frame sent at a sample enable of every 1, 2 or 4 clocks produces the same bytes and verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Line sample strobe, eight per bit time |
| rxd | input | 1 | Raw receive line, idle high |
| slot_start | input | 1 | Opens a receive slot |
| slot_end | input | 1 | Closes the slot and requests a verdict |
| byte_data | output | 8 | Last completed byte |
| byte_we | output | 1 | One-clock write pulse for `byte_data` |
| frame_ok | output | 1 | Slot verdict: data valid |
| frame_bad | output | 1 | Slot verdict: violation seen |

## Verification
The assertions check the timing properties on every cycle. Write pulses last one clock. A write is always preceded by a sample enable and falls inside an open slot. Verdicts follow only a slot end, are mutually exclusive, and only appear after an open slot. The properties that concern line content can only be shown by the bench scenarios. These are majority filtering of glitches, resynchronisation after a stretched or shrunk start bit, bit order, start-sequence coding errors, cut-off frames and the equivalence across sample rates. The bench compares recovered bytes and verdicts against frames it builds itself.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;
  typedef enum logic [2:0] {
    FR_IDLE,
    FR_DATA,
    FR_SEP_HI,
    FR_SEP_LO,
    FR_HALT
  } frm_state_t;
endpackage

// File: rtl/osr_rx_voter.sv
module osr_rx_voter #(
  parameter int VOTE_N = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic rxd,
  output logic voted
);
  localparam int CW = $clog2(VOTE_N + 1);

  logic [VOTE_N-1:0] win_q;
  logic [CW-1:0]     ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '1;
    end else if (samp_en) begin
      win_q <= {win_q[VOTE_N-2:0], rxd};
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_N; i++) begin
      ones = ones + CW'(win_q[i]);
    end
  end

  assign voted = (ones > CW'(VOTE_N / 2));
endmodule

// File: rtl/osr_rx_bit_timer.sv
module osr_rx_bit_timer #(
  parameter int OSR        = 8,
  parameter int STROBE_IDX = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic voted,
  output logic bit_stb,
  output logic bit_val
);
  localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             fall;

  assign fall = prev_q & ~voted;

  always_comb begin
    if (fall) begin
      cnt_n = '0;
    end else if (cnt_q == CNT_W'(OSR - 1)) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b1;
      cnt_q   <= '0;
      bit_stb <= 1'b0;
      bit_val <= 1'b1;
    end else if (samp_en) begin
      prev_q  <= voted;
      cnt_q   <= cnt_n;
      bit_stb <= (cnt_n == CNT_W'(STROBE_IDX));
      bit_val <= voted;
    end else begin
      bit_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/osr_rx_framer.sv
module osr_rx_framer
  import osr_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_start,
  input  logic              slot_end,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_we,
  output logic              frame_ok,
  output logic              frame_bad
);
  localparam int BC_W = $clog2(BYTE_W);

  frm_state_t        st_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BC_W-1:0]   bcnt_q;
  logic              in_slot_q;
  logic              cod_err_q;
  logic              got_q;
  logic              busy;
  logic [BYTE_W-1:0] sh_n;

  assign busy = (st_q == FR_DATA) || (st_q == FR_SEP_HI) || (st_q == FR_SEP_LO);
  assign sh_n = {sh_q[BYTE_W-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= FR_IDLE;
      sh_q      <= '0;
      bcnt_q    <= '0;
      in_slot_q <= 1'b0;
      cod_err_q <= 1'b0;
      got_q     <= 1'b0;
      byte_data <= '0;
      byte_we   <= 1'b0;
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
    end else begin
      byte_we   <= 1'b0;
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
      if (slot_end) begin
        frame_ok  <= in_slot_q && got_q && !cod_err_q && !busy;
        frame_bad <= in_slot_q && (cod_err_q || busy);
        in_slot_q <= 1'b0;
        st_q      <= FR_IDLE;
      end else if (slot_start) begin
        in_slot_q <= 1'b1;
        cod_err_q <= 1'b0;
        got_q     <= 1'b0;
        st_q      <= FR_IDLE;
      end else if (in_slot_q && bit_stb) begin
        unique case (st_q)
          FR_IDLE: begin
            if (!bit_val) begin
              st_q   <= FR_DATA;
              bcnt_q <= '0;
            end
          end
          FR_DATA: begin
            sh_q <= sh_n;
            if (bcnt_q == BC_W'(BYTE_W - 1)) begin
              byte_data <= sh_n;
              byte_we   <= 1'b1;
              got_q     <= 1'b1;
              st_q      <= FR_SEP_HI;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
          FR_SEP_HI: begin
            if (bit_val) begin
              st_q <= FR_SEP_LO;
            end else begin
              cod_err_q <= 1'b1;
              st_q      <= FR_HALT;
            end
          end
          FR_SEP_LO: begin
            if (!bit_val) begin
              st_q   <= FR_DATA;
              bcnt_q <= '0;
            end else begin
              st_q <= FR_IDLE;
            end
          end
          default: st_q <= FR_HALT;
        endcase
      end
    end
  end
endmodule

// File: rtl/osr_rx_decoder.sv
module osr_rx_decoder #(
  parameter int OSR        = 8,
  parameter int VOTE_N     = 5,
  parameter int STROBE_IDX = 4,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_en,
  input  logic              rxd,
  input  logic              slot_start,
  input  logic              slot_end,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_we,
  output logic              frame_ok,
  output logic              frame_bad
);
  logic voted;
  logic bit_stb;
  logic bit_val;

  osr_rx_voter #(.VOTE_N(VOTE_N)) u_voter (
    .clk     (clk),
    .rst     (rst),
    .samp_en (samp_en),
    .rxd     (rxd),
    .voted   (voted)
  );

  osr_rx_bit_timer #(.OSR(OSR), .STROBE_IDX(STROBE_IDX)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .samp_en (samp_en),
    .voted   (voted),
    .bit_stb (bit_stb),
    .bit_val (bit_val)
  );

  osr_rx_framer #(.BYTE_W(BYTE_W)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .slot_start (slot_start),
    .slot_end   (slot_end),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .byte_data  (byte_data),
    .byte_we    (byte_we),
    .frame_ok   (frame_ok),
    .frame_bad  (frame_bad)
  );
endmodule

// File: rtl/osr_rx_decoder_chk.sv
module osr_rx_decoder_chk (
  input logic clk,
  input logic rst,
  input logic samp_en,
  input logic slot_start,
  input logic slot_end,
  input logic byte_we,
  input logic frame_ok,
  input logic frame_bad
);
  logic chk_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_in <= 1'b0;
    end else if (slot_end) begin
      chk_in <= 1'b0;
    end else if (slot_start) begin
      chk_in <= 1'b1;
    end
  end

  AST_WE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    byte_we |=> !byte_we); // R4

  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(frame_ok && frame_bad)); // R8

  AST_VERDICT_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (frame_ok || frame_bad) |-> ($past(slot_end) && $past(chk_in))); // R8

  AST_WE_INSIDE_SLOT: assert property (@(posedge clk) disable iff (rst)
    byte_we |-> $past(chk_in && !slot_end && !slot_start)); // R10

  AST_WE_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    byte_we |-> $past(samp_en, 2)); // R11
endmodule

bind osr_rx_decoder osr_rx_decoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .samp_en    (samp_en),
  .slot_start (slot_start),
  .slot_end   (slot_end),
  .byte_we    (byte_we),
  .frame_ok   (frame_ok),
  .frame_bad  (frame_bad)
);

// File: tb/osr_rx_decoder_tb.sv
module osr_rx_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       samp_en = 1'b0;
  logic       rxd = 1'b1;
  logic       slot_start = 1'b0;
  logic       slot_end = 1'b0;
  logic [7:0] byte_data;
  logic       byte_we;
  logic       frame_ok;
  logic       frame_bad;

  int checks = 0;
  int errors = 0;
  int div = 2;
  bit done = 1'b0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] fb[8];

  always #2 clk = ~clk;

  osr_rx_decoder u_dut (
    .clk(clk), .rst(rst), .samp_en(samp_en), .rxd(rxd),
    .slot_start(slot_start), .slot_end(slot_end),
    .byte_data(byte_data), .byte_we(byte_we),
    .frame_ok(frame_ok), .frame_bad(frame_bad)
  );

  always @(negedge clk) if (!rst && byte_we) got_q.push_back(byte_data);

  task automatic chk(input bit cond, input string tag, input int act, input int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send_sample(input logic v);
    rxd = v;
    samp_en = 1'b1;
    @(negedge clk);
    samp_en = 1'b0;
    for (int i = 1; i < div; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input int len, input int gpos);
    for (int s = 0; s < len; s++) send_sample((s == gpos) ? ~v : v);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 8, -1);
  endtask

  // bad_sep: index of byte whose start-sequence high bit is sent low (>=1), 99 = none
  task automatic send_frame(input int nbytes, input int bad_sep, input bit jit,
                            input bit glitch, input bit expect_bytes);
    for (int b = 0; b < nbytes; b++) begin
      int hl;
      hl = 8;
      if (jit && b > 0) hl = 6 + 2 * int'($urandom % 3);
      if (b == bad_sep) send_bit(1'b0, 8, -1);
      else send_bit(1'b1, hl, -1);
      send_bit(1'b0, 8, -1);
      for (int i = 7; i >= 0; i--) begin
        int gp;
        gp = -1;
        if (glitch && ($urandom % 3 == 0)) gp = 3 + int'($urandom % 2);
        send_bit(fb[b][i], 8, gp);
      end
      if (expect_bytes && b < bad_sep) exp_q.push_back(fb[b]);
    end
    idle_bits(3);
  endtask

  task automatic open_slot();
    slot_start = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
    got_q.delete();
    exp_q.delete();
    idle_bits(3);
  endtask

  task automatic close_slot(input bit eok, input bit ebad, input string tag);
    slot_end = 1'b1;
    @(negedge clk);
    slot_end = 1'b0;
    chk(frame_ok == eok, {tag, " R8 frame_ok"}, frame_ok, eok);
    chk(frame_bad == ebad, {tag, " R8 frame_bad"}, frame_bad, ebad);
    @(negedge clk);
    chk(!frame_ok && !frame_bad, {tag, " R8 verdict pulse width"}, frame_ok | frame_bad, 0);
  endtask

  task automatic cmp_bytes(input string tag);
    chk(got_q.size() == exp_q.size(), {tag, " R4 byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      chk(got_q[i] == exp_q[i], {tag, " R4 byte value"}, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic rand_bytes(input int n);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(byte_we == 1'b0, "R1 byte_we after reset", byte_we, 0);
    chk(frame_ok == 1'b0, "R1 frame_ok after reset", frame_ok, 0);
    chk(frame_bad == 1'b0, "R1 frame_bad after reset", frame_bad, 0);

    // R4 R5 directed good frame
    div = 2;
    fb[0] = 8'hA5; fb[1] = 8'h00; fb[2] = 8'hFF; fb[3] = 8'h01;
    open_slot();
    send_frame(4, 99, 1'b0, 1'b0, 1'b1);
    close_slot(1'b1, 1'b0, "R5 directed frame");
    cmp_bytes("R5 directed frame");

    // R8 empty slot
    open_slot();
    idle_bits(4);
    close_slot(1'b0, 1'b0, "R8 empty slot");
    cmp_bytes("R8 empty slot");

    // R2 glitches inside data bits
    rand_bytes(6);
    open_slot();
    send_frame(6, 99, 1'b0, 1'b1, 1'b1);
    close_slot(1'b1, 1'b0, "R2 glitch frame");
    cmp_bytes("R2 glitch frame");

    // R3 stretched/shrunk start-sequence high bits
    rand_bytes(6);
    open_slot();
    send_frame(6, 99, 1'b1, 1'b0, 1'b1);
    close_slot(1'b1, 1'b0, "R3 jitter frame");
    cmp_bytes("R3 jitter frame");

    // R6 coding error in start sequence of third byte
    rand_bytes(5);
    open_slot();
    send_frame(5, 2, 1'b0, 1'b0, 1'b1);
    close_slot(1'b0, 1'b1, "R6 coding error");
    cmp_bytes("R6 coding error");

    // R9 next slot clean again
    rand_bytes(2);
    open_slot();
    send_frame(2, 99, 1'b0, 1'b0, 1'b1);
    close_slot(1'b1, 1'b0, "R9 clean after error");
    cmp_bytes("R9 clean after error");

    // R7 slot ends inside second byte
    fb[0] = 8'h3C; fb[1] = 8'h00;
    open_slot();
    send_frame(1, 99, 1'b0, 1'b0, 1'b1);
    send_bit(1'b1, 8, -1);
    send_bit(1'b0, 8, -1);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 8, -1);
    close_slot(1'b0, 1'b1, "R7 cut frame");
    cmp_bytes("R7 cut frame");

    // R10 frame outside any slot
    idle_bits(3);
    rand_bytes(2);
    send_frame(2, 99, 1'b0, 1'b0, 1'b0);
    chk(got_q.size() == 0, "R10 bytes outside slot", got_q.size(), 0);
    got_q.delete();

    // R11 same frame at fastest and slowest sample rates
    fb[0] = 8'h96; fb[1] = 8'h7E; fb[2] = 8'h81;
    for (int r = 0; r < 2; r++) begin
      div = (r == 0) ? 1 : 4;
      open_slot();
      send_frame(3, 99, 1'b0, 1'b0, 1'b1);
      close_slot(1'b1, 1'b0, "R11 rate");
      cmp_bytes("R11 rate");
    end

    // random frames, R2 R3 R4 R5 R6 mixed
    for (int k = 0; k < 15; k++) begin
      int n;
      int bs;
      n = 1 + int'($urandom % 6);
      bs = 99;
      if (n > 1 && ($urandom % 4 == 0)) bs = 1 + int'($urandom % (n - 1));
      div = 1 << ($urandom % 3);
      rand_bytes(n);
      open_slot();
      send_frame(n, bs, 1'($urandom), 1'($urandom), 1'b1);
      close_slot(bs == 99, bs != 99, "R6 random frame");
      cmp_bytes("R4 random frame");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule